// File: doc/BRIEF.md
# Line-Synchronized Soft-Start Sequencer

This block governs the start-up of a power-factor-correction stage. It waits for an enable request and for the line voltage to be qualified. It then counts rectified half-line cycles. After a programmed number of full line cycles it closes the inrush relay, always on a half-cycle boundary. After a second programmed delay it ramps a 12-bit output-voltage reference from zero to a target over one of eight fixed durations. Once the ramp has ended and the stage reports regulation with no active faults, it raises power-good.

A half-cycle boundary is a zero-crossing pulse. If no crossing arrives, a programmed maximum line period elapsing without one also counts as a boundary, so the sequence keeps moving when the crossing detector is silent. Removing the enable request or losing the line returns the block to its idle condition at once. The register bus is not part of the block: its configuration arrives as static inputs.

Top module: `pfc_softstart_seq`

## Requirements
- R1: After reset, or while idle, the outputs are as follows: brownOutFlag=1, inrushOut=0, inrushFlagN=1, blankOut=0, pgoodOut=0, pgoodFlagN=1, vrefOut=0, rampDone=0.
- R2: A sequence needs two steps. While enable=1, one clock moves the block from idle to waiting for the line. The first clock edge with lineOk=1 then starts the sequence. At that edge brownOutFlag falls to 0 and blankOut rises to 1.
- R3: A half-cycle event is either a clock edge with zeroCross=1, or an edge at which maxPeriodCfg+1 clocks have passed since the sequence started or since the last event, with no crossing in between. Events are counted only while a sequence runs.
- R4: inrushOut rises at the edge of half-cycle event number 2*inrushDelayCfg+1, counted from the start of the sequence. A code of 0 therefore means the first event. inrushFlagN is always the inverse of inrushOut.
- R5: The ramp starts at the edge of event number 2*ssDelayCfg+1. Before that edge, msTick has no effect and vrefOut stays 0.
- R6: During the ramp, each clock edge with msTick=1 adds step = ceil(targetRef/T) to vrefOut, and vrefOut saturates at targetRef. T in ms depends on rampCodeCfg. Codes 0 to 7 give 112, 168, 224, 280, 392, 504, 616 and 728.
- R7: rampDone=1 exactly while the ramp has started and vrefOut equals targetRef. The clock edge after the target is reached ends the soft-start period.
- R8: pgoodOut rises one clock after the soft-start period ends, and only if regOk=1 and flagsOk=1. It then follows regOk && flagsOk with one clock of delay. pgoodFlagN is its inverse.
- R9: enable=0 or lineOk=0 returns the block to idle at the next clock edge, from any state. In the same edge the R1 output values are restored.
- R10: blankOut=1 from the start of the sequence until the soft-start period ends, and pgoodOut=0 while blankOut=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start request for the stage |
| lineOk | input | 1 | Line RMS is above the turn-on threshold |
| zeroCross | input | 1 | One-clock pulse at each line zero crossing |
| regOk | input | 1 | Output regulation reached |
| flagsOk | input | 1 | All fault flags report OK |
| msTick | input | 1 | One-clock pulse each millisecond |
| inrushDelayCfg | input | 3 | Inrush delay in full line cycles |
| ssDelayCfg | input | 3 | Ramp start delay in full line cycles |
| rampCodeCfg | input | 3 | Ramp duration code |
| maxPeriodCfg | input | 16 | Half-cycle timeout, in clocks |
| targetRef | input | 12 | Final reference value |
| brownOutFlag | output | 1 | 1 while no sequence runs |
| inrushOut | output | 1 | Inrush relay close command |
| inrushFlagN | output | 1 | Active-low inrush flag |
| blankOut | output | 1 | Flag blanking window |
| pgoodOut | output | 1 | Power good |
| pgoodFlagN | output | 1 | Active-low power-good flag |
| vrefOut | output | 12 | Output-voltage reference |
| rampDone | output | 1 | Ramp has reached its target |

## Verification
Every result is registered behind one clock edge. A crossing, tick or drop driven before edge k shows at the outputs after edge k. The bench drives inputs on falling edges and samples on the following falling edge, so each check reads the value produced by that single edge. The timeout case is counted exactly, with inrushOut low one edge before edge 3*(maxPeriodCfg+1) after the start and high after it. Power-good is checked two edges after the final ramp tick, because the soft-start period ends one edge after the target is reached and power-good lags that by one further edge.

// File: rtl/pfcss_pkg.sv
package pfcss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LINE,
    ST_DELAY,
    ST_RAMP,
    ST_RUN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // return everything to zero at this edge
    logic countEn;  // half-cycle counting active
    logic rampEn;   // reference may advance on ms ticks
  } dpStrobe_t;

  localparam int unsigned RAMP_CODES = 8;

  function automatic int unsigned rampMsOf(input int unsigned code);
    case (code)
      0: return 112;
      1: return 168;
      2: return 224;
      3: return 280;
      4: return 392;
      5: return 504;
      6: return 616;
      default: return 728;
    endcase
  endfunction

endpackage

// File: rtl/pfcss_datapath.sv
module pfcss_datapath
  import pfcss_pkg::*;
#(
  parameter int REF_W    = 12,
  parameter int PERIOD_W = 16,
  parameter int HC_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic                zeroCross,
  input  logic                msTick,
  input  logic [PERIOD_W-1:0] maxPeriod,
  input  logic [2:0]          rampCode,
  input  logic [REF_W-1:0]    targetRef,
  output logic                hcEvt,
  output logic [HC_W-1:0]     hcCnt,
  output logic [REF_W-1:0]    vref,
  output logic                atTarget
);

  logic [PERIOD_W-1:0] periodCnt;
  logic [REF_W-1:0]    stepTab [RAMP_CODES];
  logic [REF_W-1:0]    step;
  logic [REF_W:0]      sum;

  // half-cycle boundary: crossing, or timeout with no crossing
  assign hcEvt = strobe.countEn && (zeroCross || (periodCnt >= maxPeriod));

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAll || !strobe.countEn) begin
      periodCnt <= '0;
    end else if (hcEvt) begin
      periodCnt <= '0;
    end else if (periodCnt != '1) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAll) begin
      hcCnt <= '0;
    end else if (hcEvt && (hcCnt != '1)) begin
      hcCnt <= hcCnt + 1'b1;
    end
  end

  // one constant divider per ramp duration, selected by the code
  for (genvar g = 0; g < RAMP_CODES; g++) begin : g_step
    localparam int unsigned MS = rampMsOf(g);
    assign stepTab[g] = REF_W'((32'(targetRef) + MS - 32'd1) / MS);
  end

  assign step = stepTab[rampCode];
  assign sum  = {1'b0, vref} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAll) begin
      vref <= '0;
    end else if (strobe.rampEn && msTick) begin
      if (sum >= {1'b0, targetRef}) vref <= targetRef;
      else                          vref <= sum[REF_W-1:0];
    end
  end

  assign atTarget = (vref == targetRef);

endmodule

// File: rtl/pfcss_ctrl.sv
module pfcss_ctrl
  import pfcss_pkg::*;
#(
  parameter int DLY_W = 3,
  parameter int HC_W  = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             lineOk,
  input  logic             regOk,
  input  logic             flagsOk,
  input  logic             hcEvt,
  input  logic [HC_W-1:0]  hcCnt,
  input  logic             atTarget,
  input  logic [DLY_W-1:0] inrushDelay,
  input  logic [DLY_W-1:0] ssDelay,
  output dpStrobe_t        strobe,
  output logic             inrushOn,
  output logic             pgood,
  output logic             blank,
  output logic             brownOut,
  output logic             rampDone
);

  seqState_t state, nextState;
  logic      active, nextActive;
  logic      inrushGo, rampGo;
  logic [HC_W-1:0] inrushLim, rampLim;

  // full line cycles counted as pairs of half cycles
  assign inrushLim = HC_W'({inrushDelay, 1'b0});
  assign rampLim   = HC_W'({ssDelay, 1'b0});
  assign inrushGo  = hcEvt && (hcCnt >= inrushLim);
  assign rampGo    = hcEvt && (hcCnt >= rampLim);

  always_comb begin
    nextState = state;
    if (!enable) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:      nextState = ST_WAIT_LINE;
        ST_WAIT_LINE: nextState = lineOk ? ST_DELAY : ST_WAIT_LINE;
        ST_DELAY:     nextState = !lineOk ? ST_WAIT_LINE : (rampGo ? ST_RAMP : ST_DELAY);
        ST_RAMP:      nextState = !lineOk ? ST_WAIT_LINE : (atTarget ? ST_RUN : ST_RAMP);
        ST_RUN:       nextState = !lineOk ? ST_WAIT_LINE : ST_RUN;
        default:      nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign active     = (state == ST_DELAY) || (state == ST_RAMP) || (state == ST_RUN);
  assign nextActive = (nextState == ST_DELAY) || (nextState == ST_RAMP) || (nextState == ST_RUN);

  always_comb begin
    strobe.clrAll  = !nextActive;
    strobe.countEn = active;
    strobe.rampEn  = (state == ST_RAMP);
  end

  always_ff @(posedge clk) begin
    if (rst || !nextActive) inrushOn <= 1'b0;
    else if (active && inrushGo) inrushOn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pgood <= 1'b0;
    else     pgood <= (state == ST_RUN) && (nextState == ST_RUN) && regOk && flagsOk;
  end

  assign blank    = (state == ST_DELAY) || (state == ST_RAMP);
  assign brownOut = !active;
  assign rampDone = ((state == ST_RAMP) || (state == ST_RUN)) && atTarget;

endmodule

// File: rtl/pfc_softstart_seq.sv
module pfc_softstart_seq
  import pfcss_pkg::*;
#(
  parameter int REF_W    = 12,
  parameter int PERIOD_W = 16,
  parameter int DLY_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                lineOk,
  input  logic                zeroCross,
  input  logic                regOk,
  input  logic                flagsOk,
  input  logic                msTick,
  input  logic [DLY_W-1:0]    inrushDelayCfg,
  input  logic [DLY_W-1:0]    ssDelayCfg,
  input  logic [2:0]          rampCodeCfg,
  input  logic [PERIOD_W-1:0] maxPeriodCfg,
  input  logic [REF_W-1:0]    targetRef,
  output logic                brownOutFlag,
  output logic                inrushOut,
  output logic                inrushFlagN,
  output logic                blankOut,
  output logic                pgoodOut,
  output logic                pgoodFlagN,
  output logic [REF_W-1:0]    vrefOut,
  output logic                rampDone
);

  localparam int HC_W = DLY_W + 1;

  dpStrobe_t       strobe;
  logic            hcEvt;
  logic [HC_W-1:0] hcCnt;
  logic            atTarget;

  pfcss_ctrl #(.DLY_W(DLY_W), .HC_W(HC_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .lineOk(lineOk),
    .regOk(regOk), .flagsOk(flagsOk), .hcEvt(hcEvt), .hcCnt(hcCnt),
    .atTarget(atTarget), .inrushDelay(inrushDelayCfg), .ssDelay(ssDelayCfg),
    .strobe(strobe), .inrushOn(inrushOut), .pgood(pgoodOut),
    .blank(blankOut), .brownOut(brownOutFlag), .rampDone(rampDone)
  );

  pfcss_datapath #(.REF_W(REF_W), .PERIOD_W(PERIOD_W), .HC_W(HC_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .zeroCross(zeroCross),
    .msTick(msTick), .maxPeriod(maxPeriodCfg), .rampCode(rampCodeCfg),
    .targetRef(targetRef), .hcEvt(hcEvt), .hcCnt(hcCnt), .vref(vrefOut),
    .atTarget(atTarget)
  );

  assign inrushFlagN = !inrushOut;
  assign pgoodFlagN  = !pgoodOut;

endmodule

// File: rtl/pfcss_checker.sv
module pfcss_checker #(
  parameter int REF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             lineOk,
  input logic             regOk,
  input logic             flagsOk,
  input logic [REF_W-1:0] targetRef,
  input logic             brownOutFlag,
  input logic             inrushOut,
  input logic             blankOut,
  input logic             pgoodOut,
  input logic [REF_W-1:0] vrefOut,
  input logic             rampDone
);

  AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!enable || !lineOk) |=> (brownOutFlag && !inrushOut && !pgoodOut && (vrefOut == '0))); // R9

  AST_PGOOD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    pgoodOut |-> $past(regOk && flagsOk)); // R8

  AST_NO_PGOOD_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    blankOut |-> !pgoodOut); // R10

  AST_REF_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    vrefOut <= targetRef); // R6

  AST_REF_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (!brownOutFlag && $past(!brownOutFlag)) |-> (vrefOut >= $past(vrefOut))); // R6

  AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    rampDone |-> (vrefOut == targetRef)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    brownOutFlag |-> (!blankOut && !rampDone)); // R1

endmodule

bind pfc_softstart_seq pfcss_checker #(.REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .lineOk(lineOk), .regOk(regOk),
  .flagsOk(flagsOk), .targetRef(targetRef), .brownOutFlag(brownOutFlag),
  .inrushOut(inrushOut), .blankOut(blankOut), .pgoodOut(pgoodOut),
  .vrefOut(vrefOut), .rampDone(rampDone)
);

// File: tb/pfc_softstart_seq_tb.sv
`timescale 1ns/1ps
module pfc_softstart_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 0, lineOk = 0, zeroCross = 0, regOk = 0, flagsOk = 0, msTick = 0;
  logic [2:0]  inrushDelayCfg = 0, ssDelayCfg = 0, rampCodeCfg = 0;
  logic [15:0] maxPeriodCfg = 16'd1000;
  logic [11:0] targetRef = 12'd100;
  logic        brownOutFlag, inrushOut, inrushFlagN, blankOut, pgoodOut, pgoodFlagN, rampDone;
  logic [11:0] vrefOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  pfc_softstart_seq u_dut (
    .clk(clk), .rst(rst), .enable(enable), .lineOk(lineOk), .zeroCross(zeroCross),
    .regOk(regOk), .flagsOk(flagsOk), .msTick(msTick),
    .inrushDelayCfg(inrushDelayCfg), .ssDelayCfg(ssDelayCfg), .rampCodeCfg(rampCodeCfg),
    .maxPeriodCfg(maxPeriodCfg), .targetRef(targetRef),
    .brownOutFlag(brownOutFlag), .inrushOut(inrushOut), .inrushFlagN(inrushFlagN),
    .blankOut(blankOut), .pgoodOut(pgoodOut), .pgoodFlagN(pgoodFlagN),
    .vrefOut(vrefOut), .rampDone(rampDone)
  );

  function automatic int rampMs(input int code);
    case (code)
      0: return 112; 1: return 168; 2: return 224; 3: return 280;
      4: return 392; 5: return 504; 6: return 616; default: return 728;
    endcase
  endfunction

  function automatic int stepOf(input int tgt, input int code);
    return (tgt + rampMs(code) - 1) / rampMs(code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(brownOutFlag == 1'b1, {req, " brownOutFlag"}, brownOutFlag, 1);
    check(inrushOut == 1'b0 && inrushFlagN == 1'b1, {req, " inrushOut"}, inrushOut, 0);
    check(pgoodOut == 1'b0 && pgoodFlagN == 1'b1, {req, " pgoodOut"}, pgoodOut, 0);
    check(vrefOut == 12'd0, {req, " vrefOut"}, vrefOut, 0);
    check(blankOut == 1'b0 && rampDone == 1'b0, {req, " blank/done"}, blankOut, 0);
  endtask

  task automatic startSeq();
    enable = 1'b1; lineOk = 1'b0;
    @(negedge clk); @(negedge clk);
    check(brownOutFlag == 1'b1, "R2 waiting for line", brownOutFlag, 1);
    lineOk = 1'b1;
    @(negedge clk);
    check(brownOutFlag == 1'b0, "R2 brown-out cleared", brownOutFlag, 0);
    check(blankOut == 1'b1, "R2/R10 blank on start", blankOut, 1);
    check(pgoodOut == 1'b0, "R10 no pgood in blank", pgoodOut, 0);
  endtask

  task automatic dropSeq(input bit byLine);
    if (byLine) lineOk = 1'b0; else enable = 1'b0;
    @(negedge clk);
    checkIdle("R9 drop");
    enable = 1'b0; lineOk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1; @(negedge clk); msTick = 1'b0; @(negedge clk);
  endtask

  task automatic runTrial(input int dI, input int dS, input int code, input int tgt, input bit byLine);
    int step, expRef, lastEvt;
    bit ramping;
    inrushDelayCfg = 3'(dI); ssDelayCfg = 3'(dS); rampCodeCfg = 3'(code);
    targetRef = 12'(tgt); maxPeriodCfg = 16'd1000; regOk = 1'b1; flagsOk = 1'b1;
    step = stepOf(tgt, code); expRef = 0; ramping = 0;
    lastEvt = (dI > dS) ? 2*dI + 1 : 2*dS + 1;
    startSeq();
    for (int n = 1; n <= lastEvt; n++) begin
      zeroCross = 1'b1; @(negedge clk); zeroCross = 1'b0; @(negedge clk);
      check(inrushOut == (n >= 2*dI + 1), "R4 inrush release", inrushOut, int'(n >= 2*dI + 1));
      check(inrushFlagN == !inrushOut, "R4 inrush flag", inrushFlagN, int'(!inrushOut));
      if (n >= 2*dS + 1) ramping = 1;
      tick();
      if (ramping) expRef = (expRef + step > tgt) ? tgt : expRef + step;
      check(vrefOut == 12'(expRef), ramping ? "R5 ramp started" : "R5 tick ignored before ramp",
            vrefOut, expRef);
      if (expRef < tgt) check(blankOut == 1'b1, "R10 blank during soft start", blankOut, 1);
    end
    while (expRef < tgt) begin
      tick();
      expRef = (expRef + step > tgt) ? tgt : expRef + step;
      check(vrefOut == 12'(expRef), "R6 ramp step", vrefOut, expRef);
      check(rampDone == (expRef == tgt), "R7 ramp done", rampDone, int'(expRef == tgt));
      if (expRef < tgt) check(pgoodOut == 1'b0, "R10 pgood held in ramp", pgoodOut, 0);
    end
    @(negedge clk); @(negedge clk);
    check(blankOut == 1'b0, "R7/R10 soft start ended", blankOut, 0);
    check(pgoodOut == 1'b1 && pgoodFlagN == 1'b0, "R8 pgood raised", pgoodOut, 1);
    flagsOk = 1'b0; @(negedge clk);
    check(pgoodOut == 1'b0, "R8 pgood drops on fault", pgoodOut, 0);
    flagsOk = 1'b1; @(negedge clk);
    check(pgoodOut == 1'b1, "R8 pgood returns", pgoodOut, 1);
    regOk = 1'b0; @(negedge clk);
    check(pgoodOut == 1'b0 && pgoodFlagN == 1'b1, "R8 pgood needs regulation", pgoodOut, 0);
    regOk = 1'b1; @(negedge clk);
    check(rampDone == 1'b1 && vrefOut == 12'(tgt), "R7 done holds in run", vrefOut, tgt);
    dropSeq(byLine);
  endtask

  task automatic timeoutTrial(input int m);
    inrushDelayCfg = 3'd1; ssDelayCfg = 3'd7; rampCodeCfg = 3'd0;
    targetRef = 12'd50; maxPeriodCfg = 16'(m); zeroCross = 1'b0;
    startSeq();
    repeat (3*(m+1) - 1) @(negedge clk);
    check(inrushOut == 1'b0, "R3 no release before third timeout", inrushOut, 0);
    @(negedge clk);
    check(inrushOut == 1'b1, "R3 release on third timeout", inrushOut, 1);
    dropSeq(1'b0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1 idle after reset");
    // line qualifies without enable: nothing starts
    lineOk = 1'b1; @(negedge clk); @(negedge clk);
    checkIdle("R2 needs enable");
    lineOk = 1'b0;
    runTrial(0, 0, 0, 4095, 1'b0);
    runTrial(7, 0, 7, 1, 1'b1);
    runTrial(2, 3, 3, 1000, 1'b0);
    runTrial(0, 7, 5, 777, 1'b1);
    timeoutTrial(20);
    timeoutTrial(5);
    for (int t = 0; t < 6; t++) begin
      runTrial(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
               1 + int'($urandom % 4095), t[0]);
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule